// File: doc/BRIEF.md
# Radix-Parameterized Lookahead Tree Adder

A purely combinational binary adder of `WIDTH` bits. It takes two operands and a carry input, and it returns the sum and the carry output. The fan-in of the carry lookahead is set by the parameter `RADIX`. When `RADIX` is 1, the block reduces to a plain ripple chain. When `RADIX` equals `WIDTH`, every carry is resolved in a single lookahead step. The settings in between give a regular tree whose gate count grows as O(RADIX·WIDTH).

The datapath has four layers:

- Per-bit cells form a generate term (the AND of the two operand bits) and a propagate term (the inclusive OR of the two operand bits).
- An upward tree of RADIX-input cells merges those terms into group generate/propagate terms over log_RADIX(WIDTH) levels.
- A downward tree of carry cells starts from the carry input and the root terms. It fills in every internal carry, with each cell resolving RADIX-1 carries inside its block.
- Per-bit cells form each sum bit as two chained XORs of the operand bits and the incoming carry.

`WIDTH` must be an integral power of `RADIX`. Elaboration stops with an error otherwise, except in the ripple case.

Top module: `kary_tree_adder`

## Requirements
- R1: For every input combination, {cout_o, sum_o} equals a_i + b_i + c_i as an unsigned (WIDTH+1)-bit value.
- R2: With RADIX = 1 the block is a ripple chain and still meets R1 for every input.
- R3: With RADIX = WIDTH (a single lookahead level) the block still meets R1 for every input.
- R4: When a_i ^ b_i is all ones (every bit propagates), cout_o equals c_i and every bit of sum_o equals the inverse of c_i.
- R5: When both operands are zero, cout_o is 0, sum_o bit 0 equals c_i, and all other sum bits are 0.
- R6: When both operands are all ones, cout_o is 1, sum_o bit 0 equals c_i, and all other sum bits are 1.
- R7: sum_o bit 0 always equals a_i[0] ^ b_i[0] ^ c_i.
- R8: With a_i = 1, b_i all ones and c_i = 0, a carry born in bit 0 crosses every tree level: sum_o is 0 and cout_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| c_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
The checks treat the block as settled combinational logic. They assume that every operand bit and the carry input hold a defined 0 or 1 and that these values stay stable while the outputs are compared. The stimulus meets this assumption by changing inputs only just after a rising clock edge and sampling at the following falling edge, which gives the adder half a cycle to settle. Each input is always driven with a fully defined value.

// File: rtl/kat_pkg.sv
package kat_pkg;
  // number of tree levels: log_radix(width), 0 for the ripple case
  function automatic int tree_levels(input int width, input int radix);
    int lv = 0;
    int w = width;
    if (radix < 2) return 0;
    while (w > 1) begin
      w = w / radix;
      lv++;
    end
    return lv;
  endfunction

  function automatic int ipow(input int base, input int ex);
    int r = 1;
    for (int i = 0; i < ex; i++) r = r * base;
    return r;
  endfunction
endpackage

// File: rtl/kat_group_cell.sv
module kat_group_cell #(
  parameter int RADIX = 2
) (
  input  logic [RADIX-1:0] g_i,
  input  logic [RADIX-1:0] p_i,
  output logic             g_o,
  output logic             p_o
);
  always_comb begin
    g_o = 1'b0;
    for (int t = 0; t < RADIX; t++) g_o = g_i[t] | (p_i[t] & g_o);
    p_o = &p_i;
  end
endmodule

// File: rtl/kat_carry_cell.sv
module kat_carry_cell #(
  parameter int RADIX = 2
) (
  input  logic             c_i,
  input  logic [RADIX-2:0] g_i,
  input  logic [RADIX-2:0] p_i,
  output logic [RADIX-2:0] c_o
);
  // two-level form: each carry is a sum of products over the block inputs
  always_comb begin
    for (int j = 0; j < RADIX - 1; j++) begin
      logic acc;
      logic term;
      term = c_i;
      for (int u = 0; u <= j; u++) term = term & p_i[u];
      acc = term;
      for (int t = 0; t <= j; t++) begin
        term = g_i[t];
        for (int u = t + 1; u <= j; u++) term = term & p_i[u];
        acc = acc | term;
      end
      c_o[j] = acc;
    end
  end
endmodule

// File: rtl/kary_tree_adder.sv
module kary_tree_adder #(
  parameter int WIDTH = 16,
  parameter int RADIX = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int LEVELS = kat_pkg::tree_levels(WIDTH, RADIX);

  if (RADIX < 1) begin : g_bad_radix
    $error("RADIX must be at least 1");
  end
  if (RADIX > 1 && kat_pkg::ipow(RADIX, LEVELS) != WIDTH) begin : g_bad_width
    $error("WIDTH must be an integral power of RADIX");
  end

  logic [WIDTH-1:0] bit_g, bit_p;
  logic [WIDTH:0]   carry;

  assign bit_g    = a_i & b_i;
  assign bit_p    = a_i | b_i;
  assign carry[0] = c_i;
  assign cout_o   = carry[WIDTH];
  assign sum_o    = (a_i ^ b_i) ^ carry[WIDTH-1:0];

  if (RADIX == 1) begin : g_ripple
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign carry[i+1] = bit_g[i] | (bit_p[i] & carry[i]);
    end
  end else begin : g_tree
    // upward group generate/propagate tree
    for (genvar lv = 0; lv <= LEVELS; lv++) begin : g_lvl
      localparam int CNT = WIDTH / kat_pkg::ipow(RADIX, lv);
      logic [CNT-1:0] gg, pp;
      if (lv == 0) begin : g_leaf
        assign gg = bit_g;
        assign pp = bit_p;
      end else begin : g_node
        for (genvar q = 0; q < CNT; q++) begin : g_cell
          kat_group_cell #(.RADIX(RADIX)) u_grp (
            .g_i(g_lvl[lv-1].gg[q*RADIX +: RADIX]),
            .p_i(g_lvl[lv-1].pp[q*RADIX +: RADIX]),
            .g_o(gg[q]),
            .p_o(pp[q])
          );
        end
      end
    end

    assign carry[WIDTH] = g_lvl[LEVELS].gg[0] | (g_lvl[LEVELS].pp[0] & c_i);

    // downward carry tree: level lv resolves carries inside blocks of RADIX**lv bits
    for (genvar lv = 1; lv <= LEVELS; lv++) begin : g_ctree
      localparam int SPAN   = kat_pkg::ipow(RADIX, lv);
      localparam int SUB    = SPAN / RADIX;
      localparam int BLOCKS = WIDTH / SPAN;
      for (genvar blk = 0; blk < BLOCKS; blk++) begin : g_blk
        logic [RADIX-2:0] cw;
        kat_carry_cell #(.RADIX(RADIX)) u_cry (
          .c_i(carry[blk*SPAN]),
          .g_i(g_lvl[lv-1].gg[blk*RADIX +: RADIX-1]),
          .p_i(g_lvl[lv-1].pp[blk*RADIX +: RADIX-1]),
          .c_o(cw)
        );
        for (genvar t = 0; t < RADIX - 1; t++) begin : g_out
          assign carry[blk*SPAN + (t+1)*SUB] = cw[t];
        end
      end
    end
  end
endmodule

// File: rtl/kary_tree_adder_chk.sv
module kary_tree_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             c_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o
);
  logic [WIDTH:0] ref_sum;
  assign ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, c_i};

  always_comb begin
    p_sum_exact_r1: assert ({cout_o, sum_o} == ref_sum)
      else $error("R1 sum mismatch");
    p_lsb_r7: assert (sum_o[0] == (a_i[0] ^ b_i[0] ^ c_i))
      else $error("R7 lsb mismatch");
    if ((a_i ^ b_i) == {WIDTH{1'b1}}) begin
      p_all_prop_r4: assert (cout_o == c_i && sum_o == {WIDTH{~c_i}})
        else $error("R4 propagate case");
    end
    if (a_i == '0 && b_i == '0) begin
      p_zero_r5: assert (!cout_o && sum_o == {{(WIDTH-1){1'b0}}, c_i})
        else $error("R5 zero case");
    end
    if (a_i == {WIDTH{1'b1}} && b_i == {WIDTH{1'b1}}) begin
      p_all_gen_r6: assert (cout_o && sum_o == {{(WIDTH-1){1'b1}}, c_i})
        else $error("R6 generate case");
    end
  end
endmodule

bind kary_tree_adder kary_tree_adder_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/kary_tree_adder_bench.sv
module kary_tree_adder_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0]  a8, b8;   logic c8;
  logic [3:0]  a4, b4;   logic c4;
  logic [15:0] a16, b16; logic c16;
  logic [63:0] a64, b64; logic c64;
  logic [7:0]  s8t, s8r;  logic co8t, co8r;
  logic [3:0]  s4;        logic co4;
  logic [15:0] s16t, s16f; logic co16t, co16f;
  logic [63:0] s64;       logic co64;

  kary_tree_adder #(.WIDTH(8), .RADIX(2)) u_kary_tree_adder (
    .a_i(a8), .b_i(b8), .c_i(c8), .sum_o(s8t), .cout_o(co8t));
  kary_tree_adder #(.WIDTH(8), .RADIX(1)) u_kary_tree_adder_rip (
    .a_i(a8), .b_i(b8), .c_i(c8), .sum_o(s8r), .cout_o(co8r));
  kary_tree_adder #(.WIDTH(4), .RADIX(4)) u_kary_tree_adder_w4 (
    .a_i(a4), .b_i(b4), .c_i(c4), .sum_o(s4), .cout_o(co4));
  kary_tree_adder #(.WIDTH(16), .RADIX(4)) u_kary_tree_adder_w16 (
    .a_i(a16), .b_i(b16), .c_i(c16), .sum_o(s16t), .cout_o(co16t));
  kary_tree_adder #(.WIDTH(16), .RADIX(16)) u_kary_tree_adder_flat (
    .a_i(a16), .b_i(b16), .c_i(c16), .sum_o(s16f), .cout_o(co16f));
  kary_tree_adder #(.WIDTH(64), .RADIX(4)) u_kary_tree_adder_w64 (
    .a_i(a64), .b_i(b64), .c_i(c64), .sum_o(s64), .cout_o(co64));

  task automatic chk(input string req, input logic [64:0] act, input logic [64:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_wide(input logic [63:0] a, input logic [63:0] b, input logic c);
    @(posedge clk);
    a64 = a; b64 = b; c64 = c;
    a16 = a[15:0]; b16 = b[15:0]; c16 = c;
    @(negedge clk);
  endtask

  initial begin
    {a8, b8, c8, a4, b4, c4, a16, b16, c16, a64, b64, c64} = '0;
    repeat (4) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // idle state with zero inputs: R5
    chk("R5 idle w8", 65'({co8t, s8t}), 65'd0);
    chk("R5 idle w64", 65'({co64, s64}), 65'd0);

    // exhaustive sweep: R1 (tree), R2 (ripple), R3 (single-level w4)
    for (int v = 0; v < (1 << 17); v++) begin
      @(posedge clk);
      {c8, a8, b8} = v[16:0];
      {c4, a4, b4} = v[8:0];
      @(negedge clk);
      chk("R1 w8 k2", 65'({co8t, s8t}), 65'(a8) + 65'(b8) + 65'(c8));
      chk("R2 w8 ripple", 65'({co8r, s8r}), 65'(a8) + 65'(b8) + 65'(c8));
      chk("R3 w4 k4", 65'({co4, s4}), 65'(a4) + 65'(b4) + 65'(c4));
    end

    // random vectors on wide configurations
    for (int i = 0; i < 2000; i++) begin
      drive_wide({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
      chk("R1 w16 k4", 65'({co16t, s16t}), 65'(a16) + 65'(b16) + 65'(c16));
      chk("R3 w16 k16", 65'({co16f, s16f}), 65'(a16) + 65'(b16) + 65'(c16));
      chk("R1 w64 k4", 65'({co64, s64}), 65'(a64) + 65'(b64) + 65'(c64));
      chk("R7 lsb w64", 65'(s64[0]), 65'(a64[0] ^ b64[0] ^ c64));
    end

    // directed corners
    for (int c = 0; c < 2; c++) begin
      logic ci;
      logic [63:0] r;
      ci = 1'(c);
      r = {$urandom, $urandom};
      drive_wide(r, ~r, ci);
      chk("R4 w64", 65'({co64, s64}), {ci, {64{~ci}}});
      chk("R4 w16", 65'({co16t, s16t}), 65'({ci, {16{~ci}}}));
      drive_wide('0, '0, ci);
      chk("R5 w64", 65'({co64, s64}), 65'(ci));
      chk("R5 w16", 65'({co16f, s16f}), 65'(ci));
      drive_wide('1, '1, ci);
      chk("R6 w64", 65'({co64, s64}), {1'b1, 63'h7fff_ffff_ffff_ffff, ci});
      chk("R6 w16", 65'({co16t, s16t}), 65'({1'b1, 15'h7fff, ci}));
    end
    drive_wide(64'd1, '1, 1'b0);
    chk("R8 w64", 65'({co64, s64}), {1'b1, 64'd0});
    chk("R8 w16 k4", 65'({co16t, s16t}), 65'h1_0000);
    chk("R8 w16 k16", 65'({co16f, s16f}), 65'h1_0000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule